// File: doc/BRIEF.md
# SDRAM Refresh and Idle Scheduler

This block decides when an SDRAM controller has to spend bus time on auto-refresh, and when the memory has been quiet long enough to be put into a low-power state. A prescaler counts controller clocks in steps of sixteen and produces a slow tick. Two counters run from that tick. One builds up a count of owed refreshes and raises a normal or an urgent refresh request. The other measures how long the command path has been quiet and raises an idle flag.

The command path reports activity through `cmd_busy`. It grants each refresh it issues by pulsing `refresh_ack` while `refresh_req` is high. A grant is a valid/ready transfer: `refresh_req` is the valid and `refresh_ack` is the ready. A refresh counts only in a cycle where both are high, and `refresh_ack` alone has no effect. Refreshes are granted in bursts, and every grant is followed by a fixed recovery gap. Dropping `enable` clears every counter so the configuration can be rewritten safely.

Top module: `sdram_refresh_sched`

## Requirements
- R1: The prescaler tick fires once every N×16 clocks, where N is `cfg_prescale`. N = 0 means 256, so the period is 4096 clocks. With `cfg_prescale`=0, `cfg_ref_period`=1 and `cmd_busy` low, `refresh_req` is still low after 4095 clocks and high after 4096 clocks from enable.
- R2: One owed refresh is added every `cfg_ref_period` ticks, and a value of 0 means 256 ticks. With `cfg_prescale`=1 and `cfg_ref_period`=0, the first owed refresh appears after exactly 4096 clocks.
- R3: `refresh_req` is high when at least one refresh is owed, no recovery gap is running, and `cmd_busy` is low. Outside a burst and below the urgent level, a high `cmd_busy` holds the request low.
- R4: Only a cycle in which `refresh_req` and `refresh_ack` are both high settles one owed refresh. A `refresh_ack` pulse while `refresh_req` is low is ignored.
- R5: The owed-refresh count saturates at 511 and never wraps. After 520 periods with no grants, exactly 511 grants are needed before the request drops.
- R6: `refresh_urgent` is high while the owed count is at least `cfg_urgent_thr`, where 0 means 256. While it is high, `refresh_req` is raised regardless of `cmd_busy`.
- R7: Once the first grant of a burst has been taken, requests continue regardless of `cmd_busy` until `cfg_burst_len` grants have been taken or nothing is owed. A value of 0 means 8 grants.
- R8: After each grant, `refresh_req` stays low for a recovery gap set by `cfg_rec_sel`: 0 gives 3 clocks, 1 gives 6 clocks, and 2 or 3 give 9 clocks.
- R9: `idle` rises after `cfg_idle_tmo` ticks in which `cmd_busy` stays low, where 0 means 256. A cycle with `cmd_busy` high clears the flag and its count at the next edge.
- R10: While `enable` is low, all outputs are low and every counter is cleared. After re-enable, the first refresh comes a full period later.
- R11: During reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run; low clears all counters |
| cfg_prescale | input | FIELD_W | Tick period in 16-clock units (0 means 256) |
| cfg_ref_period | input | FIELD_W | Ticks per owed refresh (0 means 256) |
| cfg_urgent_thr | input | FIELD_W | Owed count that makes the request urgent (0 means 256) |
| cfg_idle_tmo | input | FIELD_W | Quiet ticks before idle (0 means 256) |
| cfg_burst_len | input | BURST_W | Grants per burst (0 means 2^BURST_W) |
| cfg_rec_sel | input | 2 | Recovery gap selector: 3, 6 or 9 clocks |
| cmd_busy | input | 1 | Command path is active this cycle |
| refresh_ack | input | 1 | Grant of the current refresh request |
| refresh_req | output | 1 | Refresh wanted (valid) |
| refresh_urgent | output | 1 | Owed count has reached the urgent level |
| idle | output | 1 | Memory quiet for the timeout |

## Verification
The hardest state to reach is the saturated owed count. The timebase is first run at its fastest for more than 511 periods with no grants. The prescale and period fields are then rewritten to their slowest values, so no new refresh is owed for over a million clocks. The bench then grants requests until they stop and counts the grants, which shows that the count held at its maximum and did not wrap. The same freeze-by-reprogramming step is used to check that grants arriving while the request is low are discarded.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  typedef enum logic [1:0] {
    REC_SHORT    = 2'd0,
    REC_MID      = 2'd1,
    REC_LONG     = 2'd2,
    REC_LONG_ALT = 2'd3
  } rec_sel_e;

  // Recovery gap length in clocks after each granted refresh
  function automatic logic [3:0] rec_cycles(input logic [1:0] sel);
    case (rec_sel_e'(sel))
      REC_SHORT: rec_cycles = 4'd3;
      REC_MID:   rec_cycles = 4'd6;
      default:   rec_cycles = 4'd9;
    endcase
  endfunction

endpackage

// File: rtl/tick_period_ctr.sv
module tick_period_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] lim,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;

  assign hit = step && !clr && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (step) begin
      if (cnt_q >= lim)      cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1: a wrap pulse never lasts more than one cycle
  assert_tick_isolated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

endmodule

// File: rtl/refresh_pending.sv
module refresh_pending
  import refsched_pkg::*;
#(
  parameter int FIELD_W = 8,
  parameter int BURST_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               rtick,
  input  logic               cmd_busy,
  input  logic               refresh_ack,
  input  logic [FIELD_W-1:0] cfg_urgent_thr,
  input  logic [BURST_W-1:0] cfg_burst_len,
  input  logic [1:0]         cfg_rec_sel,
  output logic               refresh_req,
  output logic               refresh_urgent
);
  localparam int PEND_W = FIELD_W + 1;
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [PEND_W-1:0]  pend_q, pend_d, thr;
  logic [BURST_W:0]   bcnt_q, bcnt_d, blen;
  logic               in_burst_q, in_burst_d;
  logic [3:0]         rec_q, rec_d;
  logic               take;

  assign thr  = (cfg_urgent_thr == '0) ? {1'b1, {FIELD_W{1'b0}}} : {1'b0, cfg_urgent_thr};
  assign blen = (cfg_burst_len == '0)  ? {1'b1, {BURST_W{1'b0}}} : {1'b0, cfg_burst_len};

  assign refresh_urgent = en && (pend_q >= thr);
  assign refresh_req    = en && (pend_q != '0) && (rec_q == '0) &&
                          (in_burst_q || !cmd_busy || refresh_urgent);
  assign take           = refresh_req && refresh_ack;

  always_comb begin
    pend_d = pend_q;
    if (rtick && !take)      pend_d = (pend_q == PEND_MAX) ? pend_q : pend_q + 1'b1;
    else if (!rtick && take) pend_d = pend_q - 1'b1;

    if (take)                rec_d = rec_cycles(cfg_rec_sel);
    else if (rec_q != '0)    rec_d = rec_q - 1'b1;
    else                     rec_d = rec_q;

    in_burst_d = in_burst_q;
    bcnt_d     = bcnt_q;
    if (take) begin
      if ((pend_d == '0) || (bcnt_q + 1'b1 == blen)) begin
        in_burst_d = 1'b0;
        bcnt_d     = '0;
      end else begin
        in_burst_d = 1'b1;
        bcnt_d     = bcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0; rec_q <= '0; in_burst_q <= 1'b0; bcnt_q <= '0;
    end else if (!en) begin
      pend_q <= '0; rec_q <= '0; in_burst_q <= 1'b0; bcnt_q <= '0;
    end else begin
      pend_q <= pend_d; rec_q <= rec_d; in_burst_q <= in_burst_d; bcnt_q <= bcnt_d;
    end
  end

  // R5: a full owed count stays full until a grant is taken
  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pend_q == PEND_MAX && !take) |=> (pend_q == PEND_MAX));
  // R8: the cycle after a grant never carries a request
  assert_recovery_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !refresh_req);
  // R10: disabling clears the owed count and the gap timer
  assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pend_q == '0 && rec_q == '0 && !in_burst_q));

endmodule

// File: rtl/idle_watch.sv
module idle_watch #(
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               tick,
  input  logic               cmd_busy,
  input  logic [FIELD_W-1:0] cfg_idle_tmo,
  output logic               idle
);
  localparam int IC_W = FIELD_W + 1;

  logic [IC_W-1:0] quiet_q, tmo;

  assign tmo  = (cfg_idle_tmo == '0) ? {1'b1, {FIELD_W{1'b0}}} : {1'b0, cfg_idle_tmo};
  assign idle = en && (quiet_q >= tmo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      quiet_q <= '0;
    else if (!en || cmd_busy)        quiet_q <= '0;
    else if (tick && quiet_q != '1)  quiet_q <= quiet_q + 1'b1;
  end

  // R9: any access drops the idle flag at the next edge
  assert_busy_clears_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_busy |=> !idle);

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import refsched_pkg::*;
#(
  parameter int FIELD_W = 8,
  parameter int BURST_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [FIELD_W-1:0] cfg_prescale,
  input  logic [FIELD_W-1:0] cfg_ref_period,
  input  logic [FIELD_W-1:0] cfg_urgent_thr,
  input  logic [FIELD_W-1:0] cfg_idle_tmo,
  input  logic [BURST_W-1:0] cfg_burst_len,
  input  logic [1:0]         cfg_rec_sel,
  input  logic               cmd_busy,
  input  logic               refresh_ack,
  output logic               refresh_req,
  output logic               refresh_urgent,
  output logic               idle
);
  localparam int PS_W = FIELD_W + 4;

  logic [PS_W-1:0]    pre_lim;
  logic [FIELD_W-1:0] ref_lim;
  logic               slow_tick, ref_tick;

  // N*16-1 written as (N-1)*16+15; a zero field selects the largest period
  assign pre_lim = {((cfg_prescale == '0) ? {FIELD_W{1'b1}} : cfg_prescale - 1'b1), 4'hF};
  assign ref_lim = (cfg_ref_period == '0) ? {FIELD_W{1'b1}} : cfg_ref_period - 1'b1;

  tick_period_ctr #(.CNT_W(PS_W)) u_prescale (
    .clk(clk), .rst_n(rst_n), .clr(!enable), .step(1'b1),
    .lim(pre_lim), .hit(slow_tick)
  );

  tick_period_ctr #(.CNT_W(FIELD_W)) u_period (
    .clk(clk), .rst_n(rst_n), .clr(!enable), .step(slow_tick),
    .lim(ref_lim), .hit(ref_tick)
  );

  refresh_pending #(.FIELD_W(FIELD_W), .BURST_W(BURST_W)) u_pending (
    .clk(clk), .rst_n(rst_n), .en(enable), .rtick(ref_tick),
    .cmd_busy(cmd_busy), .refresh_ack(refresh_ack),
    .cfg_urgent_thr(cfg_urgent_thr), .cfg_burst_len(cfg_burst_len),
    .cfg_rec_sel(cfg_rec_sel),
    .refresh_req(refresh_req), .refresh_urgent(refresh_urgent)
  );

  idle_watch #(.FIELD_W(FIELD_W)) u_idle (
    .clk(clk), .rst_n(rst_n), .en(enable), .tick(slow_tick),
    .cmd_busy(cmd_busy), .cfg_idle_tmo(cfg_idle_tmo), .idle(idle)
  );

  // R11: nothing is requested while reset is held
  always_comb begin
    if (!rst_n) assert_reset_quiet_R11: assert (!refresh_req && !refresh_urgent && !idle);
  end

endmodule

// File: tb/sim_sdram_refresh_sched.sv
module sim_sdram_refresh_sched;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] cfg_prescale = 8'd1, cfg_ref_period = 8'd1, cfg_urgent_thr = 8'd200, cfg_idle_tmo = 8'd200;
  logic [2:0] cfg_burst_len = 3'd0;
  logic [1:0] cfg_rec_sel = 2'd0;
  logic       cmd_busy = 1'b0, refresh_ack = 1'b0;
  logic       refresh_req, refresh_urgent, idle;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdram_refresh_sched u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_prescale(cfg_prescale), .cfg_ref_period(cfg_ref_period),
    .cfg_urgent_thr(cfg_urgent_thr), .cfg_idle_tmo(cfg_idle_tmo),
    .cfg_burst_len(cfg_burst_len), .cfg_rec_sel(cfg_rec_sel),
    .cmd_busy(cmd_busy), .refresh_ack(refresh_ack),
    .refresh_req(refresh_req), .refresh_urgent(refresh_urgent), .idle(idle)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Clear everything, load a configuration and start counting from this negedge
  task automatic restart(input logic [7:0] ps, input logic [7:0] per, input logic [7:0] thr,
                         input logic [7:0] tmo, input logic [2:0] bl, input logic [1:0] rs,
                         input logic busy);
    enable = 1'b0; refresh_ack = 1'b0;
    step(1);
    cfg_prescale = ps; cfg_ref_period = per; cfg_urgent_thr = thr;
    cfg_idle_tmo = tmo; cfg_burst_len = bl; cfg_rec_sel = rs; cmd_busy = busy;
    enable = 1'b1;
  endtask

  // Grant every request until none comes for 15 clocks; returns the grant count
  task automatic drain(output int n);
    int quiet = 0;
    n = 0;
    while (quiet < 15) begin
      if (refresh_req) begin
        refresh_ack = 1'b1; step(1); refresh_ack = 1'b0;
        n++; quiet = 0;
      end else begin
        step(1); quiet++;
      end
    end
  endtask

  task automatic t_reset;
    check(!refresh_req && !refresh_urgent && !idle, "R11",
          {refresh_req, refresh_urgent, idle}, 0);
  endtask

  task automatic t_prescale_zero;
    restart(8'd0, 8'd1, 8'd200, 8'd200, 3'd0, 2'd0, 1'b0);
    step(4095);
    check(refresh_req == 1'b0, "R1 before 4096", refresh_req, 0);
    step(1);
    check(refresh_req == 1'b1, "R1 at 4096", refresh_req, 1);
  endtask

  task automatic t_period_zero;
    restart(8'd1, 8'd0, 8'd200, 8'd200, 3'd0, 2'd0, 1'b0);
    step(4095);
    check(refresh_req == 1'b0, "R2 before 256 ticks", refresh_req, 0);
    step(1);
    check(refresh_req == 1'b1, "R2 at 256 ticks", refresh_req, 1);
  endtask

  task automatic t_busy_burst;
    restart(8'd1, 8'd1, 8'd200, 8'd200, 3'd2, 2'd0, 1'b1);
    step(64);
    check(refresh_req == 1'b0, "R3 busy holds request", refresh_req, 0);
    cmd_busy = 1'b0; #1;
    check(refresh_req == 1'b1, "R3 request when quiet", refresh_req, 1);
    refresh_ack = 1'b1; step(1); refresh_ack = 1'b0; cmd_busy = 1'b1;
    step(3);
    check(refresh_req == 1'b1, "R7 burst ignores busy", refresh_req, 1);
    refresh_ack = 1'b1; step(1); refresh_ack = 1'b0;
    step(10);
    check(refresh_req == 1'b0, "R7 burst ends at length", refresh_req, 0);
  endtask

  task automatic t_ignore_ack;
    int n;
    restart(8'd1, 8'd1, 8'd200, 8'd200, 3'd0, 2'd0, 1'b1);
    step(32);
    cfg_prescale = 8'd0; cfg_ref_period = 8'd0;   // freeze the timebase
    refresh_ack = 1'b1;
    step(5);
    check(refresh_req == 1'b0, "R4 no request while busy", refresh_req, 0);
    refresh_ack = 1'b0; cmd_busy = 1'b0;
    drain(n);
    check(n == 2, "R4 stray grants ignored", n, 2);
  endtask

  task automatic t_recovery(input logic [1:0] sel, input int exp);
    int gap = 0;
    restart(8'd1, 8'd1, 8'd200, 8'd200, 3'd0, sel, 1'b0);
    step(32);
    refresh_ack = 1'b1; step(1); refresh_ack = 1'b0;
    while (!refresh_req && gap < 30) begin gap++; step(1); end
    check(gap == exp, "R8 recovery gap", gap, exp);
  endtask

  task automatic t_urgent;
    restart(8'd1, 8'd1, 8'd3, 8'd200, 3'd0, 2'd0, 1'b1);
    step(47);
    check(!refresh_urgent && !refresh_req, "R6 below threshold",
          {refresh_urgent, refresh_req}, 0);
    step(1);
    check(refresh_urgent && refresh_req, "R6 urgent overrides busy",
          {refresh_urgent, refresh_req}, 3);
  endtask

  task automatic t_saturate;
    int n;
    restart(8'd1, 8'd1, 8'd0, 8'd200, 3'd0, 2'd0, 1'b1);
    step(520 * 16);
    check(refresh_urgent == 1'b1, "R6 threshold zero means 256", refresh_urgent, 1);
    cfg_prescale = 8'd0; cfg_ref_period = 8'd0; cmd_busy = 1'b0;
    drain(n);
    check(n == 511, "R5 saturation at 511", n, 511);
  endtask

  task automatic t_idle;
    restart(8'd1, 8'd1, 8'd200, 8'd3, 3'd0, 2'd0, 1'b0);
    step(47);
    check(idle == 1'b0, "R9 before timeout", idle, 0);
    step(1);
    check(idle == 1'b1, "R9 at timeout", idle, 1);
    cmd_busy = 1'b1; step(1); cmd_busy = 1'b0;
    check(idle == 1'b0, "R9 access clears", idle, 0);
    step(20);
    check(idle == 1'b0, "R9 count restarted", idle, 0);
    step(44);
    check(idle == 1'b1, "R9 idle again", idle, 1);
  endtask

  task automatic t_disable;
    restart(8'd1, 8'd1, 8'd2, 8'd1, 3'd0, 2'd0, 1'b0);
    step(40);
    check(refresh_urgent && idle, "R10 setup", {refresh_urgent, idle}, 3);
    enable = 1'b0;
    step(1);
    check(!refresh_req && !refresh_urgent && !idle, "R10 outputs low",
          {refresh_req, refresh_urgent, idle}, 0);
    enable = 1'b1;
    step(15);
    check(refresh_req == 1'b0, "R10 counters cleared", refresh_req, 0);
    step(1);
    check(refresh_req == 1'b1, "R10 full period after enable", refresh_req, 1);
  endtask

  initial begin
    enable = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    step(1);
    t_prescale_zero;
    t_period_zero;
    t_busy_burst;
    t_ignore_ack;
    t_recovery(2'd0, 3);
    t_recovery(2'd1, 6);
    t_recovery(2'd2, 9);
    t_recovery(2'd3, 9);
    t_urgent;
    t_saturate;
    t_idle;
    t_disable;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule